// File: doc/BRIEF.md
# Pipelined Cache Tag Memory with Compare

This block is a single-clock tag store for a cache controller. Every control, address and data input is captured on the rising clock edge. A captured command is one of three kinds. A write stores a tag. A read returns a stored tag. A compare checks a presented tag against the stored one and reports the result on a single match bit. Read data and compare results come out of a two-register pipeline, so each result is present in the second cycle after the cycle that carried the command.

The tag data comes in through a data-input register. That register loads only while its active-low data enable is low, so a write or compare can reuse the tag that was captured earlier. The outputs are modelled as value/enable pairs in place of tri-state pads. The data drive is gated by an asynchronous active-low output enable. The match drive is gated by its own asynchronous active-low enable. A sticky flag records when a write arrives too soon after a read while the data outputs are enabled, which is the case where a shared bus would be driven from both ends.

Top module: `tagram_top`

## Requirements
- R1: While reset is high, and after it is released, `dout_oe_o`, `match_o` and `contention_o` are low until a command changes them.
- R2: A read is a selected cycle with `wr_n_i`=1 and `cmp_i`=0. If the read is presented in cycle n, `dout_o` carries the addressed entry in cycle n+2. Back-to-back reads give one result per cycle.
- R3: A write is a selected cycle with `wr_n_i`=0. When `din_en_n_i`=0 in the same cycle, the write stores the `din_i` value presented in that cycle.
- R4: The data-input register loads `din_i` only when `din_en_n_i`=0 at the clock edge and otherwise keeps its value. A write or compare with `din_en_n_i`=1 uses the value that was held.
- R5: A compare is a selected cycle with `wr_n_i`=1 and `cmp_i`=1. In cycle n+2, `match_o` is 1 if the data-input register equals the addressed entry and 0 if it does not. `match_o` holds its value until the next compare result, and a compare never raises `dout_oe_o`.
- R6: The block is selected only when `en_hi_i`=1 and `en_lo_n_i`=0. A deselected cycle leaves memory unchanged, raises no `dout_oe_o` two cycles later and leaves `match_o` unchanged.
- R7: `dout_oe_o` is high only in the cycle that holds a read result, and only while `oe_n_i`=0. It follows `oe_n_i` combinationally.
- R8: `match_oe_o` is the inverse of `match_oe_n_i`, combinationally.
- R9: A write sampled in any of the three cycles after a read, with `oe_n_i`=0 at the write's edge, sets `contention_o` after that edge. The flag stays set until reset. A write four cycles after the read, or a write with `oe_n_i`=1, does not set it.
- R10: A read or compare of an address written in the previous cycle sees the newly written value.
- R11: A selected cycle with `wr_n_i`=0 is a write even when `cmp_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_hi_i | input | 1 | Registered select, active high |
| en_lo_n_i | input | 1 | Registered select, active low |
| wr_n_i | input | 1 | Registered write select: 0 write, 1 read/compare |
| cmp_i | input | 1 | Registered compare request (with `wr_n_i`=1) |
| din_en_n_i | input | 1 | Data-input register load enable, active low |
| addr_i | input | ADDR_W | Entry address |
| din_i | input | DATA_W | Tag data in |
| oe_n_i | input | 1 | Asynchronous data output enable, active low |
| match_oe_n_i | input | 1 | Asynchronous match output enable, active low |
| dout_o | output | DATA_W | Read data value |
| dout_oe_o | output | 1 | Drive enable for `dout_o` |
| match_o | output | 1 | Compare result value |
| match_oe_o | output | 1 | Drive enable for `match_o` |
| contention_o | output | 1 | Sticky write-after-read bus hazard flag |

## Verification
Read data and compare results are due in cycle n+2 for a command presented in cycle n. The bench keeps the expectation for each command for one extra call and checks it at the falling edge that follows the second rising edge. The contention flag is due right after the write's own edge, so it is checked at the next falling edge. The two output enables are combinational, so they are checked 1 ns after the enable inputs are toggled, well clear of any clock edge.

// File: rtl/tagram_pkg.sv
package tagram_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_CMP   = 2'd3
    } op_e;

    // Select needs the high enable set and the low enable clear;
    // a write wins over a compare request.
    function automatic op_e decode_op(input logic hi, input logic lo_n,
                                      input logic wr_n, input logic cmp);
        if (!(hi && !lo_n)) return OP_NONE;
        if (!wr_n)          return OP_WRITE;
        if (cmp)            return OP_CMP;
        return OP_READ;
    endfunction

endpackage

// File: rtl/tagram_in_stage.sv
module tagram_in_stage
    import tagram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              din_en_n_i,
    output op_e               op_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
    } slot_t;

    slot_t             slot_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '{op: OP_NONE, addr: '0};
            data_q <= '0;
        end else begin
            slot_q <= '{op: op_i, addr: addr_i};
            if (!din_en_n_i) data_q <= din_i;
        end
    end

    assign op_o   = slot_q.op;
    assign addr_o = slot_q.addr;
    assign data_o = data_q;

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        din_en_n_i |=> $stable(data_o));

endmodule

// File: rtl/tagram_core.sv
module tagram_core
    import tagram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              match_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] entry;

    assign entry = mem[addr_i];

    always_ff @(posedge clk) begin
        if (op_i == OP_WRITE) mem[addr_i] <= data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
            match_o    <= 1'b0;
        end else begin
            rd_valid_o <= (op_i == OP_READ);
            if (op_i == OP_READ) rd_data_o <= entry;
            if (op_i == OP_CMP)  match_o   <= (entry == data_i);
        end
    end

    // R3
    write_store_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_WRITE) |=> (mem[$past(addr_i)] == $past(data_i)));

    // R5 R6
    match_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i != OP_CMP) |=> $stable(match_o));

endmodule

// File: rtl/tagram_hazard.sv
module tagram_hazard
    import tagram_pkg::*;
#(
    parameter int WINDOW = 3
) (
    input  logic clk,
    input  logic rst,
    input  op_e  op_i,
    input  logic oe_n_i,
    output logic flag_o
);

    logic [WINDOW-1:0] rd_hist_q;
    logic              hit;

    assign hit = (op_i == OP_WRITE) && !oe_n_i && (|rd_hist_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_hist_q <= '0;
            flag_o    <= 1'b0;
        end else begin
            rd_hist_q <= {rd_hist_q[WINDOW-2:0], (op_i == OP_READ)};
            if (hit) flag_o <= 1'b1;
        end
    end

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        flag_o |=> flag_o);

endmodule

// File: rtl/tagram_top.sv
module tagram_top
    import tagram_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 18,
    parameter int HAZARD_WIN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_hi_i,
    input  logic              en_lo_n_i,
    input  logic              wr_n_i,
    input  logic              cmp_i,
    input  logic              din_en_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              oe_n_i,
    input  logic              match_oe_n_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dout_oe_o,
    output logic              match_o,
    output logic              match_oe_o,
    output logic              contention_o
);

    op_e               in_op;
    op_e               s1_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [DATA_W-1:0] s1_data;
    logic              rd_valid;

    assign in_op = decode_op(en_hi_i, en_lo_n_i, wr_n_i, cmp_i);

    tagram_in_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_in (
        .clk        (clk),
        .rst        (rst),
        .op_i       (in_op),
        .addr_i     (addr_i),
        .din_i      (din_i),
        .din_en_n_i (din_en_n_i),
        .op_o       (s1_op),
        .addr_o     (s1_addr),
        .data_o     (s1_data)
    );

    tagram_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .op_i       (s1_op),
        .addr_i     (s1_addr),
        .data_i     (s1_data),
        .rd_valid_o (rd_valid),
        .rd_data_o  (dout_o),
        .match_o    (match_o)
    );

    tagram_hazard #(.WINDOW(HAZARD_WIN)) u_haz (
        .clk    (clk),
        .rst    (rst),
        .op_i   (in_op),
        .oe_n_i (oe_n_i),
        .flag_o (contention_o)
    );

    assign dout_oe_o  = rd_valid && !oe_n_i;
    assign match_oe_o = !match_oe_n_i;

    // R2
    read_lat_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(in_op, 2) == OP_READ));

    // R9
    hazard_set_chk: assert property (@(posedge clk) disable iff (rst)
        ((in_op == OP_WRITE) && !oe_n_i && ($past(in_op) == OP_READ)) |=> contention_o);

endmodule

// File: tb/tb_tagram_top.sv
`timescale 1ns/1ps
module tb_tagram_top;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          en_hi, en_lo_n, wr_n, cmp, din_en_n, oe_n, moe_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic [DW-1:0] dout_o;
    logic          dout_oe_o, match_o, match_oe_o, contention_o;

    always #2.5 clk = ~clk;

    tagram_top #(.ADDR_W(AW), .DATA_W(DW), .HAZARD_WIN(3)) dut (
        .clk          (clk),
        .rst          (rst),
        .en_hi_i      (en_hi),
        .en_lo_n_i    (en_lo_n),
        .wr_n_i       (wr_n),
        .cmp_i        (cmp),
        .din_en_n_i   (din_en_n),
        .addr_i       (addr),
        .din_i        (din),
        .oe_n_i       (oe_n),
        .match_oe_n_i (moe_n),
        .dout_o       (dout_o),
        .dout_oe_o    (dout_oe_o),
        .match_o      (match_o),
        .match_oe_o   (match_oe_o),
        .contention_o (contention_o)
    );

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] m_mem [N];
    logic [DW-1:0] m_dreg;
    logic          m_match, m_flag;
    logic [2:0]    m_hist;
    logic          p_rd, p_cmp, p_m;
    logic [DW-1:0] p_val;

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 37 + 5) & ((1 << DW) - 1));
    endfunction

    task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
        end
    endtask

    task automatic cyc(input logic hi, input logic lon, input logic wn, input logic cm,
                       input logic [AW-1:0] a, input logic [DW-1:0] d, input logic den,
                       input string ctx);
        logic sel, n_rd, n_cmp, n_m;
        logic [DW-1:0] n_val;
        en_hi = hi; en_lo_n = lon; wr_n = wn; cmp = cm;
        addr = a; din = d; din_en_n = den;
        sel = hi && !lon;
        n_rd = 1'b0; n_cmp = 1'b0; n_m = 1'b0; n_val = '0;
        if (!den) m_dreg = d;
        if (sel && !wn) begin
            if (!oe_n && (|m_hist)) m_flag = 1'b1;
            m_mem[a] = m_dreg;
        end else if (sel && cm) begin
            n_cmp = 1'b1;
            n_m = (m_mem[a] == m_dreg);
        end else if (sel) begin
            n_rd = 1'b1;
            n_val = m_mem[a];
        end
        m_hist = {m_hist[1:0], sel && wn && !cm};
        @(negedge clk);
        chk(contention_o == m_flag, {"R9 contention flag ", ctx}, contention_o, m_flag);
        if (p_rd) begin
            chk(dout_o == p_val, {"R2 read data ", ctx}, dout_o, p_val);
            chk(dout_oe_o == !oe_n, {"R7 output enable on read slot ", ctx}, dout_oe_o, !oe_n);
        end else begin
            chk(dout_oe_o == 1'b0, {"R6 no read slot drive ", ctx}, dout_oe_o, 0);
        end
        if (p_cmp) m_match = p_m;
        chk(match_o == m_match, {"R5 match value ", ctx}, match_o, m_match);
        p_rd = n_rd; p_cmp = n_cmp; p_m = n_m; p_val = n_val;
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d, input logic den, input string ctx);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, AW'(a), d, den, ctx);
    endtask
    task automatic rd(input int a, input string ctx);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, AW'(a), '0, 1'b1, ctx);
    endtask
    task automatic cp(input int a, input logic [DW-1:0] d, input logic den, input string ctx);
        cyc(1'b1, 1'b0, 1'b1, 1'b1, AW'(a), d, den, ctx);
    endtask
    task automatic idle();
        cyc(1'b0, 1'b0, 1'b1, 1'b0, '0, '0, 1'b1, "idle");
    endtask

    task automatic do_reset();
        rst = 1'b1;
        en_hi = 1'b0; en_lo_n = 1'b1; wr_n = 1'b1; cmp = 1'b0;
        din_en_n = 1'b1; addr = '0; din = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_dreg = '0; m_match = 1'b0; m_flag = 1'b0; m_hist = '0;
        p_rd = 1'b0; p_cmp = 1'b0; p_m = 1'b0; p_val = '0;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL R2 watchdog: actual hung expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        oe_n = 1'b0;
        moe_n = 1'b0;
        for (int i = 0; i < N; i++) m_mem[i] = '0;
        do_reset();
        // R1 reset state
        chk(dout_oe_o == 1'b0, "R1 dout_oe after reset", dout_oe_o, 0);
        chk(match_o == 1'b0, "R1 match after reset", match_o, 0);
        chk(contention_o == 1'b0, "R1 contention after reset", contention_o, 0);

        // R3 write sweep, data taken in the command cycle
        for (int a = 0; a < N; a++) wr(a, pat(a), 1'b0, "R3 write sweep");
        // R2 back-to-back read sweep
        for (int a = 0; a < N; a++) rd(a, "R2 read sweep");
        // R5 compare sweep, hit then miss
        for (int a = 0; a < N; a++) begin
            cp(a, pat(a), 1'b0, "R5 compare hit");
            cp(a, pat(a) ^ DW'(a + 1), 1'b0, "R5 compare miss");
        end
        idle(); idle();

        // R4 gated data register
        oe_n = 1'b1;
        wr(3, 8'hA5, 1'b0, "R4 load");
        wr(5, 8'h3C, 1'b1, "R4 gated write");
        rd(5, "R4 read gated write");
        cp(3, 8'h00, 1'b1, "R4 gated compare");
        idle(); idle();
        oe_n = 1'b0;
        rd(5, "R4 read back");
        idle(); idle();

        // R6 deselected cycles
        cyc(1'b0, 1'b0, 1'b0, 1'b0, AW'(7), 8'h11, 1'b0, "R6 write hi off");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, AW'(7), 8'h12, 1'b0, "R6 write lo on");
        cyc(1'b1, 1'b1, 1'b1, 1'b0, AW'(7), 8'h00, 1'b1, "R6 read deselected");
        cyc(1'b0, 1'b1, 1'b1, 1'b1, AW'(7), 8'h00, 1'b1, "R6 compare deselected");
        idle(); idle();
        rd(7, "R6 memory unchanged");
        idle(); idle();

        // R10 access right after write
        oe_n = 1'b1;
        wr(9, 8'h77, 1'b0, "R10 write");
        rd(9, "R10 read next cycle");
        wr(9, 8'h78, 1'b0, "R10 rewrite");
        cp(9, 8'h78, 1'b0, "R10 compare next cycle");
        // R11 write with compare request
        cyc(1'b1, 1'b0, 1'b0, 1'b1, AW'(10), 8'h42, 1'b0, "R11 write with cmp");
        rd(10, "R11 read back");
        idle(); idle();

        // R7 asynchronous output enable
        oe_n = 1'b0;
        rd(2, "R7 read");
        idle();
        oe_n = 1'b1; #1;
        chk(dout_oe_o == 1'b0, "R7 async disable", dout_oe_o, 0);
        oe_n = 1'b0; #1;
        chk(dout_oe_o == 1'b1, "R7 async enable", dout_oe_o, 1);
        idle();

        // R8 match output enable
        moe_n = 1'b1; #1;
        chk(match_oe_o == 1'b0, "R8 match drive off", match_oe_o, 0);
        moe_n = 1'b0; #1;
        chk(match_oe_o == 1'b1, "R8 match drive on", match_oe_o, 1);

        // R9 contention window
        do_reset();
        oe_n = 1'b0;
        rd(1, "R9 read");
        idle(); idle(); idle();
        wr(1, pat(1), 1'b0, "R9 write four cycles later");
        oe_n = 1'b1;
        rd(1, "R9 read oe off");
        wr(1, pat(1), 1'b0, "R9 write oe off");
        oe_n = 1'b0;
        rd(1, "R9 read hazard");
        idle();
        wr(1, pat(1), 1'b0, "R9 write within window");
        chk(contention_o == 1'b1, "R9 flag set", contention_o, 1);
        idle(); idle(); idle();
        chk(contention_o == 1'b1, "R9 flag sticky", contention_o, 1);
        do_reset();
        chk(contention_o == 1'b0, "R1 flag cleared by reset", contention_o, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule